// File: doc/BRIEF.md
# CPU Event Pulse Bridge

This block carries wake-up events from the event controller, which runs on the bus clock, to a processor that runs on its own free-running clock. On the bus clock side, a latch is set whenever any enabled event line fires, and it drives a level output. On the processor clock side, that level passes through a synchronizer and is turned into a pulse one cycle wide. An acknowledge, called event reset, is also produced on the processor side. It clears the latch without waiting for a bus clock edge.

Each assertion of the latch produces exactly one processor-side pulse, whatever the ratio between the two clocks. Events can arrive after the latch has been set but before the handshake has completed, as seen on the bus clock side. Such events are not dropped. They are held pending and replayed as one further latch assertion once the acknowledge has been released. Both clock domains have their own active-low reset.

Top module: `cpu_evt_bridge`

## Requirements
- R1: While the resets are applied and after they are released, with no event, `evt_lvl_o`, `c_evt_o` and `c_evt_rst_o` are all low.
- R2: An event line fires when `evt_i[k]` is 1 in a bus clock cycle while `evt_en_i[k]` is 1 (1 enables the line). Such a firing sets `evt_lvl_o` on the next `h_clk_i` rising edge. A line with its enable bit at 0 has no effect on `evt_lvl_o` or `c_evt_o`.
- R3: `evt_lvl_o` stays high until `c_evt_rst_o` rises, and it is low 1 ns after that rise, with no `h_clk_i` edge needed.
- R4: `c_evt_o` is high for exactly one `c_clk_i` cycle for each latch assertion.
- R5: `c_evt_rst_o` rises in the same `c_clk_i` cycle as `c_evt_o`.
- R6: `c_evt_rst_o` falls only after the synchronized level is low. It stays high for exactly SYNC_STAGES + 1 + RST_HOLD processor clock cycles.
- R7: A single event produces exactly one pulse, both when the processor clock is faster than the bus clock and when it is slower.
- R8: An event that fires after the latch has been set, but before the bus clock side has seen the handshake complete (including while `c_evt_rst_o` is high), is held pending. It produces exactly one further pulse.
- R9: Several events fired in one cycle, or within one handshake window, merge into a single pending replay. They never produce more than one extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk_i | input | 1 | Bus clock |
| h_rst_ni | input | 1 | Active-low reset, bus clock domain |
| evt_i | input | NUM_EVT | Event lines, one cycle high per event |
| evt_en_i | input | NUM_EVT | Per-line enable, 1 passes the line |
| evt_lvl_o | output | 1 | Latched event level, bus clock domain |
| c_clk_i | input | 1 | Processor free-running clock |
| c_rst_ni | input | 1 | Active-low reset, processor clock domain |
| c_evt_o | output | 1 | One-cycle event pulse to the processor |
| c_evt_rst_o | output | 1 | Event reset, asynchronously clears the latch |

## Verification
The hardest case to reach is an event that lands inside the handshake window. Such an event finds the latch held in clear, or already set but not yet acknowledged. To reach it, the bench waits for the rising edge of `c_evt_rst_o` and fires on the next bus clock falling edge. It also fires two events on back-to-back bus cycles, so that the second one lands while the level is still high. Both cases are repeated with the processor clock faster than the bus clock and again with it slower. Pulses are counted after each case has settled, so that a lost or duplicated pulse shows up as a count mismatch.

// File: rtl/cpu_evt_pkg.sv
package cpu_evt_pkg;
  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_HOLD = 1'b1
  } ack_state_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evt_hside.sv
module evt_hside #(
  parameter int NUM_EVT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               h_clk_i,
  input  logic               h_rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] evt_en_i,
  input  logic               ack_i,
  output logic               lvl_o
);
  logic set_any, busy, load, clr_n;
  logic armed_q, pend_q, lvl_q;

  assign set_any = |(evt_i & evt_en_i);

  // ack seen on the bus clock: handshake in flight
  evt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (h_clk_i),
    .rst_ni(h_rst_ni),
    .d_i   (ack_i),
    .q_o   (busy)
  );

  // load only once the previous handshake has been seen to complete
  assign load  = (set_any | pend_q) & ~busy & ~armed_q;
  assign clr_n = h_rst_ni & ~ack_i;

  always_ff @(posedge h_clk_i or negedge clr_n) begin
    if (!clr_n)    lvl_q <= 1'b0;
    else if (load) lvl_q <= 1'b1;
  end

  always_ff @(posedge h_clk_i or negedge h_rst_ni) begin
    if (!h_rst_ni) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (load)      armed_q <= 1'b1;
      else if (busy) armed_q <= 1'b0;
      if (load)                           pend_q <= 1'b0;
      else if (set_any && (armed_q || busy)) pend_q <= 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  assert_clear_holds_R3: assert property (@(posedge h_clk_i) disable iff (!h_rst_ni)
    busy |-> !lvl_q);
  assert_lvl_needs_arm_R8: assert property (@(posedge h_clk_i) disable iff (!h_rst_ni)
    lvl_q |-> armed_q);
  assert_pend_kept_R9: assert property (@(posedge h_clk_i) disable iff (!h_rst_ni)
    (pend_q && busy) |=> pend_q);
endmodule

// File: rtl/evt_cside.sv
module evt_cside
  import cpu_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 4
) (
  input  logic c_clk_i,
  input  logic c_rst_ni,
  input  logic lvl_i,
  output logic evt_o,
  output logic ack_o
);
  localparam int CW = $clog2(RST_HOLD + 2);
  localparam logic [CW-1:0] HOLD_LD = CW'(RST_HOLD);

  logic       lvl_c, evt_q, ack_q;
  logic [CW-1:0] cnt_q;
  ack_state_e st_q;

  evt_sync #(.STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk_i (c_clk_i),
    .rst_ni(c_rst_ni),
    .d_i   (lvl_i),
    .q_o   (lvl_c)
  );

  always_ff @(posedge c_clk_i or negedge c_rst_ni) begin
    if (!c_rst_ni) begin
      st_q  <= ACK_IDLE;
      evt_q <= 1'b0;
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      evt_q <= 1'b0;
      if (lvl_c)              cnt_q <= HOLD_LD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      case (st_q)
        ACK_IDLE: if (lvl_c) begin
          evt_q <= 1'b1;
          ack_q <= 1'b1;
          st_q  <= ACK_HOLD;
        end
        ACK_HOLD: if (!lvl_c && cnt_q == '0) begin
          ack_q <= 1'b0;
          st_q  <= ACK_IDLE;
        end
        default: st_q <= ACK_IDLE;
      endcase
    end
  end

  assign evt_o = evt_q;
  assign ack_o = ack_q;

  assert_pulse_width_R4: assert property (@(posedge c_clk_i) disable iff (!c_rst_ni)
    evt_o |=> !evt_o);
  assert_ack_with_pulse_R5: assert property (@(posedge c_clk_i) disable iff (!c_rst_ni)
    evt_o |-> ack_o);
  assert_ack_rise_only_on_pulse_R5: assert property (@(posedge c_clk_i) disable iff (!c_rst_ni)
    $rose(ack_o) |-> evt_o);
  assert_ack_release_R6: assert property (@(posedge c_clk_i) disable iff (!c_rst_ni)
    $fell(ack_o) |-> !$past(lvl_c));
  assert_one_pulse_per_ack_R7: assert property (@(posedge c_clk_i) disable iff (!c_rst_ni)
    evt_o |-> !$past(ack_o));
endmodule

// File: rtl/cpu_evt_bridge.sv
module cpu_evt_bridge #(
  parameter int NUM_EVT     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 4
) (
  input  logic               h_clk_i,
  input  logic               h_rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] evt_en_i,
  output logic               evt_lvl_o,
  input  logic               c_clk_i,
  input  logic               c_rst_ni,
  output logic               c_evt_o,
  output logic               c_evt_rst_o
);
  logic lvl, ack;

  evt_hside #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(SYNC_STAGES)) u_hside (
    .h_clk_i (h_clk_i),
    .h_rst_ni(h_rst_ni),
    .evt_i   (evt_i),
    .evt_en_i(evt_en_i),
    .ack_i   (ack),
    .lvl_o   (lvl)
  );

  evt_cside #(.SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD)) u_cside (
    .c_clk_i (c_clk_i),
    .c_rst_ni(c_rst_ni),
    .lvl_i   (lvl),
    .evt_o   (c_evt_o),
    .ack_o   (ack)
  );

  assign evt_lvl_o   = lvl;
  assign c_evt_rst_o = ack;
endmodule

// File: tb/cpu_evt_bridge_test.sv
module cpu_evt_bridge_test;
  localparam int CLK_PERIOD  = 10;
  localparam int C_FAST      = 4;
  localparam int C_SLOW      = 26;
  localparam int NUM_EVT     = 4;
  localparam int SYNC_STAGES = 2;
  localparam int RST_HOLD    = 4;
  localparam int ACK_LEN     = SYNC_STAGES + 1 + RST_HOLD;

  logic h_clk, c_clk, h_rst_n, c_rst_n;
  logic [NUM_EVT-1:0] evt, evt_en;
  logic lvl, c_evt, c_evt_rst;
  int   c_half;

  int n_chk, n_fail;
  int pulse_cnt, width_err, sync_err, async_err, run, last_run;
  logic prev_p;

  cpu_evt_bridge #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD)) uut (
    .h_clk_i(h_clk), .h_rst_ni(h_rst_n), .evt_i(evt), .evt_en_i(evt_en),
    .evt_lvl_o(lvl), .c_clk_i(c_clk), .c_rst_ni(c_rst_n),
    .c_evt_o(c_evt), .c_evt_rst_o(c_evt_rst)
  );

  initial begin h_clk = 1'b0; forever #(CLK_PERIOD/2) h_clk = ~h_clk; end
  initial begin c_clk = 1'b0; c_half = C_FAST/2; forever #(c_half) c_clk = ~c_clk; end

  // processor-side monitor, sampled away from the active edge
  initial begin
    pulse_cnt = 0; width_err = 0; sync_err = 0; run = 0; last_run = 0; prev_p = 1'b0;
    forever begin
      @(negedge c_clk);
      if (c_rst_n) begin
        if (c_evt) begin
          pulse_cnt++;
          if (prev_p) width_err++;
          if (!c_evt_rst) sync_err++;
        end
        if (c_evt_rst) run++;
        else if (run != 0) begin last_run = run; run = 0; end
      end
      prev_p = c_evt;
    end
  end

  initial begin
    async_err = 0;
    forever begin
      @(posedge c_evt_rst);
      #1;
      if (lvl) async_err++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [NUM_EVT-1:0] bits);
    @(negedge h_clk); evt = bits;
    @(negedge h_clk); evt = '0;
  endtask

  task automatic settle();
    repeat (60) @(negedge c_clk);
  endtask

  task automatic t_reset();
    h_rst_n = 1'b0; c_rst_n = 1'b0; evt = '0; evt_en = '1;
    repeat (3) @(negedge h_clk);
    check(lvl == 1'b0, "R1 lvl in reset", lvl, 0);
    check(c_evt == 1'b0, "R1 pulse in reset", c_evt, 0);
    check(c_evt_rst == 1'b0, "R1 ack in reset", c_evt_rst, 0);
    h_rst_n = 1'b1; c_rst_n = 1'b1;
    repeat (5) @(negedge h_clk);
    check({lvl, c_evt, c_evt_rst} == 3'b000, "R1 outputs after reset", {lvl, c_evt, c_evt_rst}, 0);
  endtask

  task automatic t_single(input string tag);
    int base;
    base = pulse_cnt;
    fire(4'b0001);
    check(lvl == 1'b1, {"R2 level set ", tag}, lvl, 1);
    settle();
    check(pulse_cnt - base == 1, {"R7 one pulse ", tag}, pulse_cnt - base, 1);
    check(width_err == 0, {"R4 pulse width ", tag}, width_err, 0);
    check(sync_err == 0, {"R5 ack with pulse ", tag}, sync_err, 0);
    check(last_run == ACK_LEN, {"R6 ack length ", tag}, last_run, ACK_LEN);
    check(lvl == 1'b0 && async_err == 0, {"R3 async clear ", tag}, async_err + int'(lvl), 0);
  endtask

  task automatic t_masked();
    int base;
    base = pulse_cnt;
    evt_en = 4'b1101;
    fire(4'b0010);
    check(lvl == 1'b0, "R2 masked line level", lvl, 0);
    settle();
    check(pulse_cnt - base == 0, "R2 masked line pulse", pulse_cnt - base, 0);
    evt_en = '1;
  endtask

  task automatic t_during_ack(input string tag);
    int base;
    base = pulse_cnt;
    fire(4'b0001);
    @(posedge c_evt_rst);
    fire(4'b0100);
    settle();
    check(pulse_cnt - base == 2, {"R8 event during ack ", tag}, pulse_cnt - base, 2);
    check(lvl == 1'b0, {"R8 level idle after replay ", tag}, lvl, 0);
  endtask

  task automatic t_armed();
    int base;
    base = pulse_cnt;
    @(negedge h_clk); evt = 4'b0001;
    @(negedge h_clk); evt = 4'b1000;
    @(negedge h_clk); evt = '0;
    settle();
    check(pulse_cnt - base == 2, "R8 event while level high", pulse_cnt - base, 2);
  endtask

  task automatic t_burst();
    int base;
    base = pulse_cnt;
    fire(4'b0001);
    @(posedge c_evt_rst);
    fire(4'b0010);
    fire(4'b0100);
    fire(4'b1000);
    settle();
    check(pulse_cnt - base == 2, "R9 burst merges", pulse_cnt - base, 2);
    base = pulse_cnt;
    fire(4'b1111);
    settle();
    check(pulse_cnt - base == 1, "R9 lines in one cycle", pulse_cnt - base, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_single("fast");
    t_masked();
    t_during_ack("fast");
    t_armed();
    t_burst();
    c_half = C_SLOW/2;
    settle();
    t_single("slow");
    t_during_ack("slow");
    check(width_err == 0 && sync_err == 0, "R4 R5 totals", width_err + sync_err, 0);
    finish_run();
  end
endmodule